// File: doc/BRIEF.md
# Chainable Four-Channel Event Timer

The block holds four 16-bit up-counting timer channels behind one register port. Every channel has its own two-stage prescaler, counter, match value, capture register, mode register and two sticky event flags. Each channel also has three pins: a gate input that can pause counting, a pin input that serves as a clock source and as a capture trigger, and an output that reports match events. A channel takes its count clock from one of three sources: every system clock, a shared slow tick that fires once every 16 system clocks, or rising edges on its own pin input. With both prescale stages set to zero and the system clock selected, the counter advances once per clock.

Any channel above channel 0 can be switched into chained mode. In that mode it advances only when the channel just below it wraps from all-ones. Chaining channel 1 gives a 32-bit counter from channels 0 and 1, and chaining channel 3 does the same for channels 2 and 3. Chaining channels 1, 2 and 3 gives one 64-bit counter.

The register port is plain control. A write is accepted in the cycle that `wr_en` is high, and nothing can push back on it. A read is combinational from `rd_addr`. Pins are taken to be synchronous to `clk`. The address is `{channel, reg}`, with the register index in the low three bits: 0 mode, 1 prescale, 2 count, 3 match value, 4 capture (read only), 5 events. Any other index reads zero.

Top module: `cascade_timer_array`

## Requirements
- R1: After reset, every register of every channel reads zero and all outputs are low.
- R2: Mode bits [1:0] pick the count source: 0 stopped, 1 system clock, 2 slow tick, 3 pin input rising edge. With source 1 and prescale 0 the count register rises by one on every clock, wrapping from 0xFFFF to 0.
- R3: Prescale bits [3:0] (P) and [7:4] (S) give a source-tick divisor of (P+1)*(S+1), so 0xFF divides by 256.
- R4: Source 2 counts once every 16 clocks from reset. Source 3 counts once per rising edge of the channel's pin input.
- R5: With the gate-enable mode bit [4] set, the counter and the prescaler hold while the gate pin is low.
- R6: A count step taken while the counter equals the match value sets event bit 0. The counter then goes to 0 if restart mode bit [2] is set, and otherwise it goes on incrementing.
- R7: Mode bit [3] clear: the output is high for exactly the one clock that follows a match. Mode bit [3] set: the output inverts on every match and otherwise holds.
- R8: Mode bits [6:5] pick the capture edge of the pin input (0 none, 1 rising, 2 falling, 3 both). On that edge the current count is copied into the capture register and event bit 1 is set.
- R9: Writing the event register clears each bit written as 1. Bits written as 0 are not changed. A new event in the same cycle as the clear wins over the clear.
- R10: Setting mode bit [7] on channel 1 (or 3) makes it advance only when the channel below wraps from 0xFFFF, forming a 32-bit counter.
- R11: With channels 1, 2 and 3 all chained, the four channels count as one 64-bit counter. Bit [7] has no effect on channel 0.
- R12: A write to the count register loads that value and takes priority over a count step. A write to the prescale register restarts both prescale stages from zero.
- R13: A chained channel ignores its own source select, prescale and gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address {channel, reg} |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Read address {channel, reg} |
| rd_data | output | 16 | Combinational read data |
| gate_in | input | 4 | Per-channel gate pins |
| tin | input | 4 | Per-channel clock/capture pins |
| tout | output | 4 | Per-channel match outputs |

## Verification
The bench drives carries through the 32-bit and 64-bit chains from values just below all-ones. A broken carry path would show as an upper word that stays still or that steps on every clock. It runs the largest prescale divisor and restarts the prescaler mid-count, which would expose an off-by-one in either stage or a stale stage count. It also sets up matches together with clears of the event register, where a design that lets the clear win would lose events. Capture on both edges and toggle versus pulse output modes are compared on every clock. Random register traffic with random pins then exercises gate, source and chain changes in the middle of a count.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [2:0] {
    RG_MODE = 3'd0,
    RG_PSC  = 3'd1,
    RG_CNT  = 3'd2,
    RG_REF  = 3'd3,
    RG_CAP  = 3'd4,
    RG_EVT  = 3'd5
  } reg_e;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_SYS  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_PIN  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef struct packed {
    logic  chain;
    edge_e cap_edge;
    logic  gate_en;
    logic  toggle;
    logic  restart;
    src_e  src;
  } mode_t;

  localparam int unsigned MODE_W  = $bits(mode_t);
  localparam int unsigned REG_SEL = 3;
  localparam int unsigned EVT_W   = 2;

endpackage

// File: rtl/ctmr_prescale.sv
module ctmr_prescale #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [PW-1:0] pri_lim,
  input  logic [PW-1:0] sec_lim,
  output logic          tick
);

  logic [PW-1:0] pri_q;
  logic [PW-1:0] sec_q;
  logic          pri_last;
  logic          sec_last;

  assign pri_last = (pri_q == pri_lim);
  assign sec_last = (sec_q == sec_lim);
  assign tick     = adv && pri_last && sec_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else if (clr) begin
      pri_q <= '0;
      sec_q <= '0;
    end else if (adv) begin
      if (pri_last) begin
        pri_q <= '0;
        sec_q <= sec_last ? '0 : sec_q + 1'b1;
      end else begin
        pri_q <= pri_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
  import ctmr_pkg::*;
#(
  parameter int unsigned CW        = 16,
  parameter int unsigned PW        = 4,
  parameter bit          HAS_LOWER = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_sel,
  input  logic [REG_SEL-1:0]  wr_reg,
  input  logic [CW-1:0]       wr_data,
  input  logic [REG_SEL-1:0]  rd_reg,
  output logic [CW-1:0]       rd_data,
  input  logic                slow_tick,
  input  logic                tin,
  input  logic                gate,
  input  logic                carry_in,
  output logic                carry_out,
  output logic                tout,
  output logic                tick_o,
  output logic                hit_o,
  output logic [CW-1:0]       cnt_o,
  output logic                evt_ref_o
);

  mode_t             mode_q;
  logic [2*PW-1:0]   psc_q;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     ref_q;
  logic [CW-1:0]     cap_q;
  logic [EVT_W-1:0]  evt_q;
  logic              tin_q;
  logic              tout_q;

  logic tin_rise, tin_fall, src_tick, run, chained;
  logic pre_adv, pre_tick, tick, hit, cap_hit;
  logic wr_mode, wr_psc, wr_cnt, wr_ref, wr_evt;
  logic [EVT_W-1:0] clr_mask;

  assign wr_mode = wr_sel && (wr_reg == RG_MODE);
  assign wr_psc  = wr_sel && (wr_reg == RG_PSC);
  assign wr_cnt  = wr_sel && (wr_reg == RG_CNT);
  assign wr_ref  = wr_sel && (wr_reg == RG_REF);
  assign wr_evt  = wr_sel && (wr_reg == RG_EVT);

  assign tin_rise = tin & ~tin_q;
  assign tin_fall = ~tin & tin_q;

  always_comb begin
    case (mode_q.src)
      SRC_SYS:  src_tick = 1'b1;
      SRC_SLOW: src_tick = slow_tick;
      SRC_PIN:  src_tick = tin_rise;
      default:  src_tick = 1'b0;
    endcase
  end

  assign run     = ~(mode_q.gate_en & ~gate);
  assign chained = HAS_LOWER && mode_q.chain;
  assign pre_adv = run && src_tick && !chained;

  ctmr_prescale #(.PW(PW)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (wr_psc),
    .adv     (pre_adv),
    .pri_lim (psc_q[PW-1:0]),
    .sec_lim (psc_q[2*PW-1:PW]),
    .tick    (pre_tick)
  );

  assign tick      = chained ? carry_in : pre_tick;
  assign hit       = tick && (cnt_q == ref_q);
  assign carry_out = tick && (&cnt_q);

  always_comb begin
    case (mode_q.cap_edge)
      EDGE_RISE: cap_hit = tin_rise;
      EDGE_FALL: cap_hit = tin_fall;
      EDGE_BOTH: cap_hit = tin_rise | tin_fall;
      default:   cap_hit = 1'b0;
    endcase
  end

  assign clr_mask = wr_evt ? wr_data[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      psc_q  <= '0;
      cnt_q  <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
      evt_q  <= '0;
      tin_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      tin_q <= tin;
      if (wr_mode) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      if (wr_psc)  psc_q  <= wr_data[2*PW-1:0];
      if (wr_ref)  ref_q  <= wr_data;
      if (cap_hit) cap_q  <= cnt_q;

      if (wr_cnt)    cnt_q <= wr_data;
      else if (tick) cnt_q <= (hit && mode_q.restart) ? '0 : cnt_q + 1'b1;

      evt_q <= (evt_q & ~clr_mask) | {cap_hit, hit};

      if (hit)                 tout_q <= mode_q.toggle ? ~tout_q : 1'b1;
      else if (!mode_q.toggle) tout_q <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_reg)
      RG_MODE: rd_data[MODE_W-1:0] = mode_q;
      RG_PSC:  rd_data[2*PW-1:0]   = psc_q;
      RG_CNT:  rd_data             = cnt_q;
      RG_REF:  rd_data             = ref_q;
      RG_CAP:  rd_data             = cap_q;
      RG_EVT:  rd_data[EVT_W-1:0]  = evt_q;
      default: rd_data             = '0;
    endcase
  end

  assign tout      = tout_q;
  assign tick_o    = tick;
  assign hit_o     = hit;
  assign cnt_o     = cnt_q;
  assign evt_ref_o = evt_q[0];

endmodule

// File: rtl/cascade_timer_array.sv
module cascade_timer_array
  import ctmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CW     = 16,
  parameter int unsigned PW     = 4,
  parameter int unsigned SLOW_W = 4,
  localparam int unsigned CHW   = $clog2(NCH),
  localparam int unsigned AW    = CHW + REG_SEL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [CW-1:0]  rd_data,
  input  logic [NCH-1:0] gate_in,
  input  logic [NCH-1:0] tin,
  output logic [NCH-1:0] tout
);

  logic [SLOW_W-1:0]         slow_q;
  logic                      slow_tick;
  logic [CHW-1:0]            wr_ch;
  logic [CHW-1:0]            rd_ch;
  logic [NCH-1:0]            carry;
  logic                      top_carry_unused;
  logic [NCH-1:0][CW-1:0]    rd_vec;
  logic [NCH-1:0]            dbg_tick;
  logic [NCH-1:0]            dbg_hit;
  logic [NCH-1:0]            dbg_evt_ref;
  logic [NCH-1:0][CW-1:0]    dbg_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_q <= '0;
    else        slow_q <= slow_q + 1'b1;
  end

  assign slow_tick        = &slow_q;
  assign wr_ch            = wr_addr[AW-1:REG_SEL];
  assign rd_ch            = rd_addr[AW-1:REG_SEL];
  assign top_carry_unused = carry[NCH-1];

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [CHW-1:0] KID = CHW'(k);
    logic cin;

    if (k == 0) begin : g_base
      assign cin = 1'b0;
    end else begin : g_link
      assign cin = carry[k-1];
    end

    ctmr_channel #(
      .CW        (CW),
      .PW        (PW),
      .HAS_LOWER (k != 0)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_en && (wr_ch == KID)),
      .wr_reg    (wr_addr[REG_SEL-1:0]),
      .wr_data   (wr_data),
      .rd_reg    (rd_addr[REG_SEL-1:0]),
      .rd_data   (rd_vec[k]),
      .slow_tick (slow_tick),
      .tin       (tin[k]),
      .gate      (gate_in[k]),
      .carry_in  (cin),
      .carry_out (carry[k]),
      .tout      (tout[k]),
      .tick_o    (dbg_tick[k]),
      .hit_o     (dbg_hit[k]),
      .cnt_o     (dbg_cnt[k]),
      .evt_ref_o (dbg_evt_ref[k])
    );
  end

  assign rd_data = rd_vec[rd_ch];

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker
  import ctmr_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned AW  = CHW + REG_SEL
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_addr,
  input logic                   clr_bit0,
  input logic [NCH-1:0]         tout,
  input logic [NCH-1:0]         dbg_tick,
  input logic [NCH-1:0]         dbg_hit,
  input logic [NCH-1:0]         dbg_evt_ref,
  input logic [NCH-1:0][CW-1:0] dbg_cnt
);

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    localparam logic [CHW-1:0] KID = CHW'(k);
    logic wr_cnt_k;
    logic wr_evt_k;

    assign wr_cnt_k = wr_en && (wr_addr[AW-1:REG_SEL] == KID) && (wr_addr[REG_SEL-1:0] == RG_CNT);
    assign wr_evt_k = wr_en && (wr_addr[AW-1:REG_SEL] == KID) && (wr_addr[REG_SEL-1:0] == RG_EVT);

    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_tick[k] && !dbg_hit[k] && !wr_cnt_k |=> dbg_cnt[k] == $past(dbg_cnt[k]) + 1'b1); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_tick[k] && !wr_cnt_k |=> $stable(dbg_cnt[k])); // R5

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_hit[k] |=> dbg_evt_ref[k]); // R6

    AST_OUT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tout[k]) |-> $past(dbg_hit[k])); // R7

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt_k && clr_bit0 && !dbg_hit[k] |=> !dbg_evt_ref[k]); // R9
  end

endmodule

bind cascade_timer_array ctmr_checker #(.NCH(NCH), .CW(CW)) u_ctmr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .clr_bit0    (wr_data[0]),
  .tout        (tout),
  .dbg_tick    (dbg_tick),
  .dbg_hit     (dbg_hit),
  .dbg_evt_ref (dbg_evt_ref),
  .dbg_cnt     (dbg_cnt)
);

// File: tb/cascade_timer_array_bench.sv
`timescale 1ns/1ps
module cascade_timer_array_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [3:0]  gate_in = '0;
  logic [3:0]  tin = '0;
  logic [3:0]  tout;

  int m_mode [4];
  int m_psc  [4];
  int m_cnt  [4];
  int m_ref  [4];
  int m_cap  [4];
  int m_evt  [4];
  int m_p1   [4];
  int m_p2   [4];
  int m_tout [4];
  int m_tinq [4];
  int m_slow;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cascade_timer_array u_cascade_timer_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .gate_in (gate_in),
    .tin     (tin),
    .tout    (tout)
  );

  // behavioural reference model, updated at each rising edge
  always @(posedge clk or negedge rst_n) begin : model
    bit tk [4];
    bit hit [4];
    bit cy [4];
    bit cp [4];
    bit av [4];
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_mode[k] = 0; m_psc[k] = 0; m_cnt[k] = 0; m_ref[k] = 0; m_cap[k] = 0;
        m_evt[k] = 0; m_p1[k] = 0; m_p2[k] = 0; m_tout[k] = 0; m_tinq[k] = 0;
      end
      m_slow = 0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        bit src, run, chn, rise, fall;
        rise = tin[k] && (m_tinq[k] == 0);
        fall = !tin[k] && (m_tinq[k] != 0);
        case (m_mode[k] & 3)
          0: src = 0;
          1: src = 1;
          2: src = (m_slow == 15);
          default: src = rise;
        endcase
        run = (((m_mode[k] >> 4) & 1) == 0) || gate_in[k];
        chn = (k > 0) && (((m_mode[k] >> 7) & 1) == 1);
        av[k] = run && src && !chn;
        if (chn) tk[k] = cy[k-1];
        else tk[k] = av[k] && (m_p1[k] == (m_psc[k] & 15)) && (m_p2[k] == ((m_psc[k] >> 4) & 15));
        hit[k] = tk[k] && (m_cnt[k] == m_ref[k]);
        cy[k]  = tk[k] && (m_cnt[k] == 16'hFFFF);
        case ((m_mode[k] >> 5) & 3)
          1: cp[k] = rise;
          2: cp[k] = fall;
          3: cp[k] = rise || fall;
          default: cp[k] = 0;
        endcase
      end
      for (int k = 0; k < 4; k++) begin
        bit sel;
        int rg, clr, tog;
        sel = wr_en && (int'(wr_addr[4:3]) == k);
        rg  = int'(wr_addr[2:0]);
        tog = (m_mode[k] >> 3) & 1;
        if (sel && rg == 1) begin
          m_p1[k] = 0; m_p2[k] = 0;
        end else if (av[k]) begin
          if (m_p1[k] == (m_psc[k] & 15)) begin
            m_p1[k] = 0;
            m_p2[k] = (m_p2[k] == ((m_psc[k] >> 4) & 15)) ? 0 : m_p2[k] + 1;
          end else m_p1[k] = m_p1[k] + 1;
        end
        if (cp[k]) m_cap[k] = m_cnt[k];
        if (sel && rg == 2) m_cnt[k] = int'(wr_data);
        else if (tk[k]) m_cnt[k] = (hit[k] && ((m_mode[k] >> 2) & 1) == 1) ? 0 : (m_cnt[k] + 1) & 16'hFFFF;
        clr = (sel && rg == 5) ? int'(wr_data) & 3 : 0;
        m_evt[k] = (m_evt[k] & ~clr) | (cp[k] ? 2 : 0) | (hit[k] ? 1 : 0);
        if (hit[k]) m_tout[k] = (tog == 1) ? 1 - m_tout[k] : 1;
        else if (tog == 0) m_tout[k] = 0;
        m_tinq[k] = tin[k] ? 1 : 0;
        if (sel && rg == 0) m_mode[k] = int'(wr_data) & 255;
        if (sel && rg == 1) m_psc[k]  = int'(wr_data) & 255;
        if (sel && rg == 3) m_ref[k]  = int'(wr_data);
      end
      m_slow = (m_slow + 1) % 16;
    end
  end

  function automatic int model_read(int k, int r);
    case (r)
      0: return m_mode[k];
      1: return m_psc[k];
      2: return m_cnt[k];
      3: return m_ref[k];
      4: return m_cap[k];
      5: return m_evt[k];
      default: return 0;
    endcase
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // compare every register and pin against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int k = 0; k < 4; k++) begin
        for (int r = 0; r < 6; r++) begin
          rd_addr = 5'(k * 8 + r);
          #0.01;
          check(rd_data, 16'(model_read(k, r)), $sformatf("ch%0d reg%0d", k, r));
        end
        check(16'(tout[k]), 16'(m_tout[k]), $sformatf("ch%0d tout", k));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic wr(int ch, int rg, int d);
    wr_en   = 1'b1;
    wr_addr = 5'(ch * 8 + rg);
    wr_data = 16'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  function automatic int md(int src, int rst = 0, int tog = 0, int gate = 0, int edg = 0, int chn = 0);
    return src | (rst << 2) | (tog << 3) | (gate << 4) | (edg << 5) | (chn << 7);
  endfunction

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cur_req = "R1";
    cyc(3);

    cur_req = "R2";
    wr(0, 0, md(1));
    cyc(20);
    wr(0, 0, 0);
    cyc(5);

    cur_req = "R3";
    wr(1, 1, 8'h23);
    wr(1, 0, md(1));
    cyc(60);
    wr(1, 1, 8'hFF);
    cyc(600);
    wr(1, 0, 0);

    cur_req = "R4";
    wr(2, 0, md(2));
    cyc(70);
    wr(2, 0, 0);
    wr(3, 0, md(3));
    repeat (10) begin
      tin[3] = 1'b1; cyc(2);
      tin[3] = 1'b0; cyc(3);
    end
    wr(3, 0, 0);

    cur_req = "R5";
    wr(0, 2, 0);
    wr(0, 0, md(1, 0, 0, 1));
    gate_in[0] = 1'b0; cyc(10);
    gate_in[0] = 1'b1; cyc(10);
    repeat (8) begin
      gate_in[0] = ~gate_in[0]; cyc(3);
    end

    cur_req = "R6";
    wr(0, 3, 5);
    wr(0, 2, 0);
    wr(0, 0, md(1, 1));
    cyc(30);
    wr(1, 3, 7);
    wr(1, 2, 0);
    wr(1, 1, 0);
    wr(1, 0, md(1));
    cyc(30);

    cur_req = "R7";
    wr(0, 0, md(1, 1, 1));
    cyc(30);

    cur_req = "R8";
    wr(2, 1, 0);
    for (int e = 1; e < 4; e++) begin
      wr(2, 0, md(1, 0, 0, 0, e));
      repeat (3) begin
        cyc(2); tin[2] = 1'b1; cyc(3); tin[2] = 1'b0;
      end
    end

    cur_req = "R9";
    wr(0, 5, 0);
    cyc(2);
    wr(2, 5, 1);
    cyc(2);
    wr(2, 5, 2);
    wr(1, 5, 3);
    wr(0, 5, 1);
    cyc(3);

    cur_req = "R10";
    for (int k = 0; k < 4; k++) wr(k, 0, 0);
    wr(0, 1, 0);
    wr(0, 2, 16'hFFF0);
    wr(1, 2, 16'h0000);
    wr(1, 3, 16'h0003);
    wr(1, 0, md(0, 0, 1, 0, 0, 1));
    wr(0, 0, md(1));
    cyc(40);

    cur_req = "R11";
    wr(0, 0, md(0, 0, 0, 0, 0, 1));
    wr(2, 0, md(0, 0, 0, 0, 0, 1));
    wr(3, 0, md(0, 0, 0, 0, 0, 1));
    wr(0, 2, 16'hFFF0);
    wr(1, 2, 16'hFFFF);
    wr(2, 2, 16'hFFFF);
    wr(3, 2, 16'h0005);
    wr(0, 0, md(1, 0, 0, 0, 0, 1));
    cyc(40);

    cur_req = "R13";
    wr(1, 0, md(2, 0, 0, 1, 0, 1));
    wr(1, 1, 8'h77);
    gate_in[1] = 1'b0;
    wr(0, 2, 16'hFFF8);
    cyc(20);

    cur_req = "R12";
    for (int k = 0; k < 4; k++) wr(k, 0, 0);
    wr(0, 1, 8'h33);
    wr(0, 0, md(1));
    cyc(7);
    wr(0, 1, 8'h33);
    cyc(20);
    wr(0, 2, 16'h1234);
    cyc(5);

    cur_req = "R6";
    repeat (3000) begin
      tin     = 4'($urandom);
      gate_in = 4'($urandom);
      wr_en   = ($urandom % 4) == 0;
      wr_addr = 5'((($urandom % 4) * 8) + ($urandom % 6));
      wr_data = 16'($urandom);
      cyc();
    end
    wr_en = 1'b0;
    cyc(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule